// File: doc/BRIEF.md
# Nested Page Shadow-Stack Permission Checker

This block decides whether one memory access is allowed by the second-level translation that maps guest-physical to host-physical addresses. A separate walker presents the entries of one walk to it, one entry per cycle, and flags the last one as the leaf. The checker keeps running permission terms across the walk. When the leaf is accepted it registers a single verdict: allow, or a violation with a reason code. The verdict appears on the next cycle together with a valid strobe.

Supervisor shadow-stack accesses follow their own rules when the protection feature is enabled. A page the tables mark as shadow stack takes shadow-stack reads and writes even when its write bit is clear. A shadow-stack access that lands on an unmarked page is refused. Ordinary writes to a marked read-only page are still refused. Two entry formats are supported and are selected per walk. Each format has its own rule for marking a page and its own source for the enable bit.

Top module: `nptShadowPermChecker`

## Requirements
- R1: A verdict (`allowOut`, `reasonOut`) is presented with `validOut` high exactly one cycle after an entry with `entryValid` and `entryLeaf` both high is accepted. `validOut` is low in every other cycle and after reset.
- R2: If any entry of the walk is not present, the reason is 1 (not present) and this takes priority over all other reasons. In format A, present means bit 0 = 1. In format B, present means at least one of bits 2:0 is 1.
- R3: With the feature enabled, a shadow-stack read (access code 3) or shadow-stack write (code 4) to an unmarked page gives reason 2.
- R4: With the feature enabled, a shadow-stack read or write to a marked page is allowed, even when the write bit (bit 1) is 0 in any entry.
- R5: An ordinary write (code 1) is allowed only if bit 1 is 1 in every entry of the walk; otherwise the reason is 3. This holds for marked pages too.
- R6: In format A (`fmtB`=0), a page is marked only when the leaf has bit 63 (no-execute) = 1 and bit 2 (user) = 0, and every non-leaf entry has bit 1 = 1.
- R7: In format B (`fmtB`=1), a page is marked when bit 60 of the leaf is 1.
- R8: The feature enable is bit 7 of `rootPtr` in format B and bit 4 of `ctrlWord` in format A; the other source is ignored.
- R9: With the feature disabled, a shadow-stack read is checked like an ordinary read (code 0) and a shadow-stack write like an ordinary write.
- R10: Permission terms are ANDed across all entries of one walk and restart at the first entry of the next walk.
- R11: A fetch (code 2) is refused with reason 5 unless every entry allows execution (format A: bit 63 = 0; format B: bit 2 = 1). A read is refused with reason 4 unless every entry has bit 0 = 1.
- R12: When `validOut` is high, `allowOut` is 1 exactly when `reasonOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| entryValid | input | 1 | An entry is presented this cycle |
| entryLeaf | input | 1 | The presented entry is the last of the walk |
| entry | input | ENTRY_W | Translation entry |
| fmtB | input | 1 | Entry format select: 0 = format A, 1 = format B |
| rootPtr | input | ROOT_W | Table-root pointer; holds the format B enable |
| ctrlWord | input | CTRL_W | Control word; holds the format A enable |
| accType | input | 3 | Access: 0 read, 1 write, 2 fetch, 3 shadow-stack read, 4 shadow-stack write; sampled with the leaf |
| validOut | output | 1 | Verdict strobe |
| allowOut | output | 1 | Access allowed |
| reasonOut | output | 3 | 0 none, 1 not present, 2 unmarked shadow-stack page, 3 write to read-only, 4 read denied, 5 execute denied |

## Verification
The bench builds the block with its default parameters: 64-bit entries, the mark at bit 60, no-execute at bit 63, and the enables at bit 7 of the root pointer and bit 4 of the control word. These are the exact positions named in the requirements, so every marking rule and both enable sources can be reached from the ports. Random walks of one to four entries in both formats can hit a not-present entry or a cleared write bit at any depth. They can also produce format A walks where only an upper-level entry breaks the mark, and back-to-back walks that show whether the accumulators restart.

// File: rtl/nptChkPkg.sv
package nptChkPkg;
  typedef enum logic [2:0] {
    ACC_READ    = 3'd0,
    ACC_WRITE   = 3'd1,
    ACC_FETCH   = 3'd2,
    ACC_SSREAD  = 3'd3,
    ACC_SSWRITE = 3'd4
  } accKind_t;

  typedef enum logic [2:0] {
    RSN_NONE       = 3'd0,
    RSN_NOTPRESENT = 3'd1,
    RSN_SSUNMARKED = 3'd2,
    RSN_WRITERO    = 3'd3,
    RSN_NOREAD     = 3'd4,
    RSN_NOEXEC     = 3'd5
  } reason_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAcc;   // first entry of a walk
    logic accept;   // an entry is taken this cycle
    logic finish;   // the leaf is taken this cycle
  } walkStrobe_t;
endpackage

// File: rtl/nptChkCtrl.sv
module nptChkCtrl
  import nptChkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        entryValid,
  input  logic        entryLeaf,
  output walkStrobe_t strobe
);
  logic inWalk;

  always_ff @(posedge clk) begin
    if (!rstN) inWalk <= 1'b0;
    else if (entryValid) inWalk <= !entryLeaf;
  end

  always_comb begin
    strobe.accept = entryValid;
    strobe.clrAcc = entryValid && !inWalk;
    strobe.finish = entryValid && entryLeaf;
  end
endmodule

// File: rtl/nptChkDatapath.sv
module nptChkDatapath
  import nptChkPkg::*;
#(
  parameter int ENTRY_W     = 64,
  parameter int ROOT_W      = 64,
  parameter int CTRL_W      = 32,
  parameter int MARK_BIT    = 60,
  parameter int NX_BIT      = 63,
  parameter int ROOT_EN_BIT = 7,
  parameter int CTRL_EN_BIT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strobe,
  input  logic [ENTRY_W-1:0] entry,
  input  logic               fmtB,
  input  logic [ROOT_W-1:0]  rootPtr,
  input  logic [CTRL_W-1:0]  ctrlWord,
  input  logic [2:0]         accType,
  output logic               validOut,
  output logic               allowOut,
  output logic [2:0]         reasonOut
);
  localparam int RD_BIT = 0;
  localparam int WR_BIT = 1;
  localparam int XU_BIT = 2;   // user bit in format A, execute bit in format B

  logic accRd, accWr, accEx, accPres, accNlRw;
  logic eRd, eWr, eEx, ePres;
  logic bRd, bWr, bEx, bPres, bNlRw;
  logic curRd, curWr, curEx, curPres;
  logic marked, featEn, isSs, isWr, isFetch;
  accKind_t kind;
  reason_t  reasonNext;

  always_comb begin
    eRd   = entry[RD_BIT];
    eWr   = entry[WR_BIT];
    eEx   = fmtB ? entry[XU_BIT] : !entry[NX_BIT];
    ePres = fmtB ? |entry[XU_BIT:RD_BIT] : entry[RD_BIT];

    bRd   = strobe.clrAcc ? 1'b1 : accRd;
    bWr   = strobe.clrAcc ? 1'b1 : accWr;
    bEx   = strobe.clrAcc ? 1'b1 : accEx;
    bPres = strobe.clrAcc ? 1'b1 : accPres;
    bNlRw = strobe.clrAcc ? 1'b1 : accNlRw;

    curRd   = bRd & eRd;
    curWr   = bWr & eWr;
    curEx   = bEx & eEx;
    curPres = bPres & ePres;

    marked = fmtB ? entry[MARK_BIT]
                  : (entry[NX_BIT] && !entry[XU_BIT] && bNlRw);
    featEn = fmtB ? rootPtr[ROOT_EN_BIT] : ctrlWord[CTRL_EN_BIT];

    kind    = accKind_t'(accType);
    isSs    = (kind == ACC_SSREAD) || (kind == ACC_SSWRITE);
    isWr    = (kind == ACC_WRITE) || (kind == ACC_SSWRITE && !featEn);
    isFetch = (kind == ACC_FETCH);

    if (!curPres)            reasonNext = RSN_NOTPRESENT;
    else if (isSs && featEn) reasonNext = marked ? RSN_NONE : RSN_SSUNMARKED;
    else if (isWr)           reasonNext = curWr ? RSN_NONE : RSN_WRITERO;
    else if (isFetch)        reasonNext = curEx ? RSN_NONE : RSN_NOEXEC;
    else                     reasonNext = curRd ? RSN_NONE : RSN_NOREAD;
  end

  // running permission terms across one walk
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accRd <= 1'b1; accWr <= 1'b1; accEx <= 1'b1;
      accPres <= 1'b1; accNlRw <= 1'b1;
    end else if (strobe.accept) begin
      accRd   <= curRd;
      accWr   <= curWr;
      accEx   <= curEx;
      accPres <= curPres;
      accNlRw <= strobe.finish ? bNlRw : (bNlRw & eWr);
    end
  end

  // registered verdict
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validOut  <= 1'b0;
      allowOut  <= 1'b0;
      reasonOut <= RSN_NONE;
    end else begin
      validOut <= strobe.finish;
      if (strobe.finish) begin
        allowOut  <= (reasonNext == RSN_NONE);
        reasonOut <= reasonNext;
      end
    end
  end
endmodule

// File: rtl/nptShadowPermChecker.sv
module nptShadowPermChecker
  import nptChkPkg::*;
#(
  parameter int ENTRY_W     = 64,
  parameter int ROOT_W      = 64,
  parameter int CTRL_W      = 32,
  parameter int MARK_BIT    = 60,
  parameter int NX_BIT      = 63,
  parameter int ROOT_EN_BIT = 7,
  parameter int CTRL_EN_BIT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               entryValid,
  input  logic               entryLeaf,
  input  logic [ENTRY_W-1:0] entry,
  input  logic               fmtB,
  input  logic [ROOT_W-1:0]  rootPtr,
  input  logic [CTRL_W-1:0]  ctrlWord,
  input  logic [2:0]         accType,
  output logic               validOut,
  output logic               allowOut,
  output logic [2:0]         reasonOut
);
  walkStrobe_t strobe;

  nptChkCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .entryValid(entryValid), .entryLeaf(entryLeaf),
    .strobe(strobe)
  );

  nptChkDatapath #(
    .ENTRY_W(ENTRY_W), .ROOT_W(ROOT_W), .CTRL_W(CTRL_W), .MARK_BIT(MARK_BIT),
    .NX_BIT(NX_BIT), .ROOT_EN_BIT(ROOT_EN_BIT), .CTRL_EN_BIT(CTRL_EN_BIT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .entry(entry), .fmtB(fmtB),
    .rootPtr(rootPtr), .ctrlWord(ctrlWord), .accType(accType),
    .validOut(validOut), .allowOut(allowOut), .reasonOut(reasonOut)
  );
endmodule

// File: rtl/nptChkAsserts.sv
module nptChkAsserts (
  input logic       clk,
  input logic       rstN,
  input logic       entryValid,
  input logic       entryLeaf,
  input logic       fmtB,
  input logic       rootEn,
  input logic       ctrlEn,
  input logic [2:0] accType,
  input logic       validOut,
  input logic       allowOut,
  input logic [2:0] reasonOut
);
  logic featEn;
  assign featEn = fmtB ? rootEn : ctrlEn;

  // R1: strobe exactly one cycle after an accepted leaf
  p_valid_after_leaf_r1: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && entryLeaf) |=> validOut);
  p_no_stray_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(entryValid && entryLeaf) |=> !validOut);

  // R12: allow agrees with a zero reason
  p_allow_reason_r12: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (allowOut == (reasonOut == 3'd0)));

  // R3: unmarked-page reason only for an enabled shadow-stack access
  p_unmarked_src_r3: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && entryLeaf && !(featEn && (accType == 3'd3 || accType == 3'd4)))
      |=> (reasonOut != 3'd2));

  // R5: read-only reason only for a write that is checked as ordinary
  p_writero_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && entryLeaf && !(accType == 3'd1 || (accType == 3'd4 && !featEn)))
      |=> (reasonOut != 3'd3));
endmodule

bind nptShadowPermChecker nptChkAsserts u_asserts (
  .clk(clk), .rstN(rstN), .entryValid(entryValid), .entryLeaf(entryLeaf),
  .fmtB(fmtB), .rootEn(rootPtr[ROOT_EN_BIT]), .ctrlEn(ctrlWord[CTRL_EN_BIT]),
  .accType(accType), .validOut(validOut), .allowOut(allowOut),
  .reasonOut(reasonOut)
);

// File: tb/test_nptShadowPermChecker.sv
module test_nptShadowPermChecker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        entryValid = 1'b0;
  logic        entryLeaf = 1'b0;
  logic [63:0] entry = '0;
  logic        fmtB = 1'b0;
  logic [63:0] rootPtr = '0;
  logic [31:0] ctrlWord = '0;
  logic [2:0]  accType = '0;
  logic        validOut, allowOut;
  logic [2:0]  reasonOut;

  int checks = 0;
  int errors = 0;
  logic [63:0] ents [4];

  always #2 clk = ~clk;

  nptShadowPermChecker i_nptShadowPermChecker (
    .clk(clk), .rstN(rstN), .entryValid(entryValid), .entryLeaf(entryLeaf),
    .entry(entry), .fmtB(fmtB), .rootPtr(rootPtr), .ctrlWord(ctrlWord),
    .accType(accType), .validOut(validOut), .allowOut(allowOut),
    .reasonOut(reasonOut)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // expected {allow, reason} from the requirements
  function automatic logic [3:0] model(int n);
    logic pres = 1, rd = 1, wr = 1, ex = 1, nl = 1, mk, en, ss, isW;
    logic [63:0] lf = ents[n-1];
    for (int i = 0; i < n; i++) begin
      logic [63:0] e = ents[i];
      pres &= fmtB ? |e[2:0] : e[0];
      rd &= e[0];
      wr &= e[1];
      ex &= fmtB ? e[2] : !e[63];
      if (i < n-1) nl &= e[1];
    end
    mk  = fmtB ? lf[60] : (lf[63] && !lf[2] && nl);
    en  = fmtB ? rootPtr[7] : ctrlWord[4];
    ss  = (accType == 3'd3) || (accType == 3'd4);
    isW = (accType == 3'd1) || (accType == 3'd4 && !en);
    if (!pres)       return {1'b0, 3'd1};
    if (ss && en)    return mk ? {1'b1, 3'd0} : {1'b0, 3'd2};
    if (isW)         return wr ? {1'b1, 3'd0} : {1'b0, 3'd3};
    if (accType == 3'd2) return ex ? {1'b1, 3'd0} : {1'b0, 3'd5};
    return rd ? {1'b1, 3'd0} : {1'b0, 3'd4};
  endfunction

  task automatic doWalk(int n, string req);
    logic [3:0] exp = model(n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      entry = ents[i]; entryLeaf = (i == n-1); entryValid = 1'b1;
    end
    @(negedge clk);
    entryValid = 1'b0; entryLeaf = 1'b0;
    check({req, " valid"}, {7'd0, validOut}, 8'd1);
    check({req, " allow"}, {7'd0, allowOut}, {7'd0, exp[3]});
    check({req, " reason"}, {5'd0, reasonOut}, {5'd0, exp[2:0]});
  endtask

  function automatic logic [63:0] randEnt(logic b);
    logic [63:0] e = {$urandom, $urandom};
    if (b) begin
      e[0] = ($urandom % 6) != 0; e[1] = ($urandom % 3) != 0;
      e[2] = ($urandom % 2) != 0; e[60] = ($urandom % 2) != 0;
    end else begin
      e[0] = ($urandom % 8) != 0; e[1] = ($urandom % 3) != 0;
    end
    return e;
  endfunction

  // format B page: read=1, write=0, exec=0, marked
  localparam logic [63:0] B_RO_MARK = 64'h1000_0000_0000_0001;
  localparam logic [63:0] B_RW      = 64'h0000_0000_0000_0007;
  // format A: present, rw, supervisor, no-execute
  localparam logic [63:0] A_NL_RW   = 64'h0000_0000_0000_0003;
  localparam logic [63:0] A_LEAF_SS = 64'h8000_0000_0000_0001;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {7'd0, validOut}, 8'd0);
    rstN = 1'b1;

    // R4: enabled shadow-stack write to marked read-only page (format B)
    fmtB = 1; rootPtr = 64'h80; accType = 3'd4;
    ents[0] = B_RW; ents[1] = B_RO_MARK; doWalk(2, "R4 sswrite marked");
    @(negedge clk);
    check("R1 strobe drops", {7'd0, validOut}, 8'd0);
    accType = 3'd3; doWalk(2, "R4 ssread marked");
    // R5: ordinary write to that page
    accType = 3'd1; doWalk(2, "R5 write ro marked");
    // R3 and R7: unmarked page
    accType = 3'd3; ents[1] = B_RW; doWalk(2, "R3 R7 ssread unmarked");
    // R9: disabled, shadow-stack write to read-only page
    rootPtr = 64'h0; accType = 3'd4; ents[1] = B_RO_MARK;
    doWalk(2, "R9 disabled sswrite");
    // R8: format B ignores ctrlWord
    ctrlWord = 32'h10; doWalk(2, "R8 ctrl ignored in B");
    // R8 and R6: format A enable from ctrl bit 4 only
    fmtB = 0; ctrlWord = 32'h0; rootPtr = 64'h80; accType = 3'd4;
    ents[0] = A_NL_RW; ents[1] = A_LEAF_SS; doWalk(2, "R8 root ignored in A");
    ctrlWord = 32'h10; doWalk(2, "R6 marked A");
    ents[0] = 64'h1; doWalk(2, "R6 nonleaf ro unmarked");
    ents[0] = A_NL_RW; ents[1] = A_LEAF_SS | 64'h4; doWalk(2, "R6 user leaf");
    // R2: not-present upper entry beats everything
    ents[0] = 64'h2; ents[1] = A_LEAF_SS; doWalk(2, "R2 not present");
    // R11: fetch from no-execute page, read in format B without read bit
    accType = 3'd2; ents[0] = A_NL_RW; doWalk(2, "R11 noexec");
    fmtB = 1; accType = 3'd0; ents[0] = 64'h6; ents[1] = B_RW;
    doWalk(2, "R11 noread");
    // R10: after a denying walk a clean walk is allowed
    accType = 3'd1; ents[0] = B_RO_MARK; doWalk(1, "R10 deny");
    ents[0] = B_RW; doWalk(1, "R10 restart");

    // random mix, R12 checked through the allow/reason pair
    for (int t = 0; t < 400; t++) begin
      int n = 1 + ($urandom % 4);
      fmtB = $urandom % 2;
      rootPtr = {$urandom, $urandom}; ctrlWord = $urandom;
      accType = 3'($urandom % 5);
      for (int i = 0; i < n; i++) ents[i] = randEnt(fmtB);
      if (!fmtB && ($urandom % 2)) begin
        for (int i = 0; i < n-1; i++) ents[i][1:0] = 2'b11;
        ents[n-1][63] = 1'b1; ents[n-1][2] = 1'b0; ents[n-1][0] = 1'b1;
      end
      doWalk(n, "R12 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule